// File: doc/BRIEF.md
# Floating-Side Handshake Responder

This block is the digital sequencer of the floating high-side gate driver in a half-bridge whose two driver dies share one isolation capacitor. The high side has no control wire of its own. The low side announces each edge by switching its end of the shared capacitor, and a bidirectional current detector on the high side reports the resulting current pulse as either a positive or a negative indication. The responder decodes that polarity. It acknowledges the pulse by moving its own capacitor switch, which sends a current pulse of its own back across the capacitor. It then sequences the high-side gate.

After a rising acknowledgement, the gate is enabled in one of two ways. In fixed mode it follows a programmable dead time. In adaptive mode it follows the end of the transition current that the midpoint swing drives through the capacitor. Samples of that current are blanked for a few clocks after the switch moves, so that the block's own acknowledgement pulse is not taken for a transition. A timeout forces the gate on when no end of transition is seen. A falling pulse moves the switch back to the supply rail and drops the gate on the same clock edge. A pulse whose polarity does not fit the current phase is ignored and flagged for one cycle.

Top module: `float_hs_responder`

## Requirements
- R1: During reset and right after reset, `sw_gnd` = 0 (switch on the local supply rail), `gate_on` = 0 and `proto_err` = 0.
- R2: In the idle state (`sw_gnd`=0, `gate_on`=0), a cycle with `det_pos`=1 and `det_neg`=0 sets `sw_gnd` to 1 (switch on local ground) at the next clock edge, while `gate_on` stays 0.
- R3: In fixed mode (`adaptive_en`=0), `gate_on` rises exactly max(`dead_time`,1) clock edges after the edge that set `sw_gnd`.
- R4: In adaptive mode, once `trans_active` has been sampled high outside the blanking window, the first later edge at which it is sampled low sets `gate_on`.
- R5: `trans_active` samples taken at the first BLANK (default 4) edges after `sw_gnd` is set are ignored.
- R6: In adaptive mode, if no end of transition is detected, `gate_on` is forced high max(`timeout`,1) edges after the edge that set `sw_gnd`.
- R7: While `gate_on`=1, a cycle with `det_neg`=1 and `det_pos`=0 clears both `sw_gnd` and `gate_on` at the next edge.
- R8: Any pulse indication that does not fit the phase is ignored and raises `proto_err` for exactly the next cycle. This covers `det_neg` in idle, `det_pos` while the gate is on, either indication while waiting for turn-on, and both indications at once.
- R9: While `startup_ok`=0, the next edge returns the block to idle from any state (`sw_gnd`=0, `gate_on`=0), and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| startup_ok | input | 1 | Start-up acknowledged by the local supply; low holds idle |
| det_pos | input | 1 | Detector: positive (rising-edge) signalling pulse |
| det_neg | input | 1 | Detector: negative (falling-edge) signalling pulse |
| trans_active | input | 1 | Detector: transition current flowing |
| adaptive_en | input | 1 | 1 = end-of-transition turn-on, 0 = fixed dead time |
| dead_time | input | CW | Fixed dead time in clocks |
| timeout | input | CW | Adaptive-mode timeout in clocks |
| sw_gnd | output | 1 | Capacitor switch select: 1 = local ground, 0 = supply rail |
| gate_on | output | 1 | High-side gate command |
| proto_err | output | 1 | One-cycle flag for an out-of-phase pulse |

## Verification
The assertions assume the detector presents each signalling pulse as a one-cycle indication that is stable around the sampling edge. They also assume that no pulse arrives while the internal reset synchronizer is still releasing. The stimulus drives every input on the falling clock edge. It holds `startup_ok` low until several cycles after reset is released, and it gives each pulse exactly one cycle. The assertions also assume that `dead_time`, `timeout` and `adaptive_en` do not change while a turn-on is pending. The bench changes these settings only while the block is idle.

// File: rtl/float_hs_pkg.sv
package float_hs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARM  = 2'd1,
    PH_ON   = 2'd2
  } phase_t;

endpackage

// File: rtl/float_hs_turnon_timer.sv
module float_hs_turnon_timer #(
  parameter int CW    = 8,
  parameter int BLANK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          adaptive_en,
  input  logic          trans_active,
  input  logic [CW-1:0] dead_time,
  input  logic [CW-1:0] timeout,
  output logic          fire
);

  localparam logic [CW:0] BLANK_W = (CW+1)'(BLANK);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic [CW:0]   elapsed;
  logic          open_win;
  logic          fixed_hit;
  logic          limit_hit;
  logic          end_hit;

  assign elapsed   = {1'b0, cnt_q} + (CW+1)'(1);
  assign open_win  = ({1'b0, cnt_q} >= BLANK_W);
  assign fixed_hit = (elapsed >= {1'b0, dead_time});
  assign limit_hit = (elapsed >= {1'b0, timeout});
  assign end_hit   = seen_q && !trans_active;

  always_comb begin
    if (!run) begin
      fire = 1'b0;
    end else if (adaptive_en) begin
      fire = end_hit || limit_hit;
    end else begin
      fire = fixed_hit;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (!run) begin
      cnt_d  = '0;
      seen_d = 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + CW'(1);
      end
      if (open_win && trans_active) begin
        seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

endmodule

// File: rtl/float_hs_phase_fsm.sv
module float_hs_phase_fsm
  import float_hs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   startup_ok,
  input  logic   det_pos,
  input  logic   det_neg,
  input  logic   fire,
  output phase_t phase,
  output logic   proto_err
);

  phase_t phase_q, phase_d;
  logic   err_q, err_d;
  logic   only_pos, only_neg, any_pulse;

  assign only_pos  = det_pos && !det_neg;
  assign only_neg  = det_neg && !det_pos;
  assign any_pulse = det_pos || det_neg;

  always_comb begin
    phase_d = phase_q;
    err_d   = 1'b0;
    if (!startup_ok) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (only_pos) begin
            phase_d = PH_ARM;
          end else if (any_pulse) begin
            err_d = 1'b1;
          end
        end
        PH_ARM: begin
          err_d = any_pulse;
          if (fire) begin
            phase_d = PH_ON;
          end
        end
        PH_ON: begin
          if (only_neg) begin
            phase_d = PH_IDLE;
          end else if (any_pulse) begin
            err_d = 1'b1;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= err_d;
    end
  end

  assign phase     = phase_q;
  assign proto_err = err_q;

endmodule

// File: rtl/float_hs_responder.sv
module float_hs_responder
  import float_hs_pkg::*;
#(
  parameter int CW    = 8,
  parameter int BLANK = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          startup_ok,
  input  logic          det_pos,
  input  logic          det_neg,
  input  logic          trans_active,
  input  logic          adaptive_en,
  input  logic [CW-1:0] dead_time,
  input  logic [CW-1:0] timeout,
  output logic          sw_gnd,
  output logic          gate_on,
  output logic          proto_err
);

  logic [1:0] rst_pipe;
  logic       core_rst_n;
  phase_t     phase;
  logic       fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe[1];

  float_hs_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .startup_ok (startup_ok),
    .det_pos    (det_pos),
    .det_neg    (det_neg),
    .fire       (fire),
    .phase      (phase),
    .proto_err  (proto_err)
  );

  float_hs_turnon_timer #(
    .CW    (CW),
    .BLANK (BLANK)
  ) u_timer (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .run          (phase == PH_ARM),
    .adaptive_en  (adaptive_en),
    .trans_active (trans_active),
    .dead_time    (dead_time),
    .timeout      (timeout),
    .fire         (fire)
  );

  assign sw_gnd  = (phase != PH_IDLE);
  assign gate_on = (phase == PH_ON);

endmodule

// File: rtl/float_hs_responder_chk.sv
module float_hs_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic startup_ok,
  input logic det_pos,
  input logic det_neg,
  input logic sw_gnd,
  input logic gate_on,
  input logic proto_err
);

  // R3
  gate_needs_gnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> sw_gnd);

  // R3
  gate_after_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(sw_gnd));

  // R2
  rise_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_ok && !sw_gnd && det_pos && !det_neg) |=> (sw_gnd && !gate_on));

  // R7
  fall_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_ok && gate_on && det_neg && !det_pos) |=> (!sw_gnd && !gate_on));

  // R8
  idle_neg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_ok && !sw_gnd && det_neg) |=> (proto_err && !sw_gnd));

  // R9
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !startup_ok |=> (!sw_gnd && !gate_on && !proto_err));

endmodule

bind float_hs_responder float_hs_responder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .startup_ok (startup_ok),
  .det_pos    (det_pos),
  .det_neg    (det_neg),
  .sw_gnd     (sw_gnd),
  .gate_on    (gate_on),
  .proto_err  (proto_err)
);

// File: tb/float_hs_responder_tb.sv
module float_hs_responder_tb;

  localparam int CW    = 8;
  localparam int BLANK = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          startup_ok;
  logic          det_pos;
  logic          det_neg;
  logic          trans_active;
  logic          adaptive_en;
  logic [CW-1:0] dead_time;
  logic [CW-1:0] timeout;
  logic          sw_gnd;
  logic          gate_on;
  logic          proto_err;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R1";
  bit    done    = 0;

  // reference model state
  int m_phase;    // 0 idle, 1 waiting, 2 gate on
  int m_edges;
  bit m_saw;
  bit m_err;

  float_hs_responder #(.CW(CW), .BLANK(BLANK)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .startup_ok   (startup_ok),
    .det_pos      (det_pos),
    .det_neg      (det_neg),
    .trans_active (trans_active),
    .adaptive_en  (adaptive_en),
    .dead_time    (dead_time),
    .timeout      (timeout),
    .sw_gnd       (sw_gnd),
    .gate_on      (gate_on),
    .proto_err    (proto_err)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_edges = 0; m_saw = 0; m_err = 0;
    end else if (!startup_ok) begin
      m_phase = 0; m_err = 0;
    end else begin
      m_err = 0;
      if (m_phase == 0) begin
        if (det_pos && !det_neg) begin
          m_phase = 1; m_edges = 0; m_saw = 0;
        end else if (det_pos || det_neg) m_err = 1;
      end else if (m_phase == 1) begin
        bit end_seen;
        int lim;
        if (det_pos || det_neg) m_err = 1;
        m_edges = m_edges + 1;
        end_seen = m_saw && !trans_active;
        if (adaptive_en) begin
          lim = (int'(timeout) < 1) ? 1 : int'(timeout);
          if (m_edges > BLANK && trans_active) m_saw = 1;
          if (end_seen || m_edges >= lim) m_phase = 2;
        end else begin
          lim = (int'(dead_time) < 1) ? 1 : int'(dead_time);
          if (m_edges >= lim) m_phase = 2;
        end
      end else begin
        if (det_neg && !det_pos) m_phase = 0;
        else if (det_pos || det_neg) m_err = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit e_sw, e_gate;
      e_sw   = (m_phase != 0);
      e_gate = (m_phase == 2);
      n_tests++;
      if (sw_gnd !== e_sw || gate_on !== e_gate || proto_err !== m_err) begin
        n_fail++;
        $display("FAIL %s: sw_gnd=%b gate_on=%b proto_err=%b expected %b %b %b",
                 cur_req, sw_gnd, gate_on, proto_err, e_sw, e_gate, m_err);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit p, input bit n);
    @(negedge clk); det_pos = p; det_neg = n;
    @(negedge clk); det_pos = 0; det_neg = 0;
  endtask

  initial begin
    rst_n = 0; startup_ok = 0; det_pos = 0; det_neg = 0; trans_active = 0;
    adaptive_en = 0; dead_time = 8'd3; timeout = 8'd20;
    cyc(3);
    rst_n = 1;
    cyc(5);
    startup_ok = 1;
    cyc(2);

    cur_req = "R2"; pulse(1, 0);
    cur_req = "R3"; cyc(5);
    cur_req = "R7"; pulse(0, 1); cyc(2);

    cur_req = "R3"; dead_time = 8'd0;
    pulse(1, 0); cyc(3); pulse(0, 1); cyc(1);
    dead_time = 8'd1; pulse(1, 0); cyc(2); pulse(0, 1); cyc(1);

    cur_req = "R8"; dead_time = 8'd10;
    pulse(0, 1); cyc(1);
    pulse(1, 1); cyc(1);
    pulse(1, 0); pulse(1, 0); cyc(1); pulse(0, 1); cyc(10);
    pulse(1, 0); cyc(1); pulse(0, 1); cyc(2);

    cur_req = "R4"; adaptive_en = 1; timeout = 8'd40;
    pulse(1, 0); cyc(5);
    trans_active = 1; cyc(3); trans_active = 0; cyc(3);
    pulse(0, 1); cyc(2);

    cur_req = "R5"; timeout = 8'd12;
    pulse(1, 0); trans_active = 1; cyc(3); trans_active = 0; cyc(12);
    pulse(0, 1); cyc(2);

    cur_req = "R6"; timeout = 8'd20;
    pulse(1, 0); cyc(24); pulse(0, 1); cyc(1);
    timeout = 8'd0; pulse(1, 0); cyc(3); pulse(0, 1); cyc(2);

    cur_req = "R9"; adaptive_en = 0; dead_time = 8'd2;
    pulse(1, 0); cyc(4);
    startup_ok = 0; cyc(2);
    pulse(0, 1); cyc(1);
    startup_ok = 1; cyc(1);
    pulse(1, 0); startup_ok = 0; cyc(2); startup_ok = 1; cyc(3);

    cur_req = "R1"; rst_n = 0; cyc(2); rst_n = 1; cyc(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule